// File: doc/BRIEF.md
# Interrupt Controller Mode Register with Transition Guard

This block holds the mode and base-address state of a local interrupt controller. The state is a global enable, an extended-mode enable, a bootstrap flag and a 20-bit base field. Software writes a full 32-bit word. The block checks whether the requested move between the disabled, xAPIC and x2APIC modes is legal.

An illegal request is refused: the state stays as it was and an error pulse is raised. A legal request loads the base field and applies the enable handling. When the block first enters x2APIC mode, it builds the extended logical ID from the initial controller ID. When the controller is disabled, the block sends a one-cycle pulse. The neighbouring spurious-vector logic uses that pulse to clear its software-enable bit.

Write word layout: bits 31:12 carry the base, bit 11 is the enable request and bit 10 is the extended-mode request. All other bits are ignored. The bootstrap flag cannot be written. It takes the value of an input while reset is active.

Top module: `apic_mode_ctl`

## Requirements
- R1: While reset is active, and after reset is released, the mode is xAPIC (`mode` = 2'b01). `bsp` equals `bsp_in`. `base_addr` equals the reset parameter (20'hFEE00). `log_id` is 0. `wr_err` and `swen_clr` are 0.
- R2: A write with bit 10 set is refused while `x2_capable` is low.
- R3: A write with bit 10 set and bit 11 clear is refused.
- R4: A write with bits 11 and 10 both set is refused while the mode is disabled (2'b00).
- R5: A write with bit 11 set and bit 10 clear is refused while the mode is x2APIC (2'b11).
- R6: A refused write leaves `mode`, `base_addr`, `bsp` and `log_id` unchanged. It raises `wr_err` for exactly the one cycle after the write edge, and `swen_clr` stays low.
- R7: An accepted write loads `base_addr` from bits 31:12 in the cycle after the write edge. `bsp` never changes after reset, whatever bit 8 of the write holds.
- R8: An accepted write with bit 11 clear sets the mode to disabled (2'b00). It also clears extended mode and pulses `swen_clr` for one cycle.
- R9: From disabled, an accepted write with bit 11 set and bit 10 clear returns the mode to xAPIC.
- R10: An accepted write with bits 11 and 10 set, made from xAPIC, enters x2APIC. `log_id` becomes `{init_id[19:4], 16'b0}` ORed with a one-hot bit at position `init_id[3:0]`.
- R11: An accepted write with bits 11 and 10 set, made while already in x2APIC, keeps the mode and leaves `log_id` unchanged, even if `init_id` has changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bsp_in | input | 1 | Bootstrap flag loaded while reset is active |
| x2_capable | input | 1 | High when the core supports extended mode |
| init_id | input | 32 | Initial controller ID |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Requested register word |
| mode | output | 2 | 00 disabled, 01 xAPIC, 11 x2APIC |
| base_addr | output | 20 | Base field |
| bsp | output | 1 | Bootstrap flag |
| log_id | output | 32 | Extended logical ID |
| wr_err | output | 1 | One-cycle pulse on a refused write |
| swen_clr | output | 1 | One-cycle pulse when the controller is disabled |

## Verification
Two functions can land on the same write: the refusal check and the disable handling. A word with bit 11 clear asks for a disable, but if bit 10 is also set the word is illegal. The bench sends exactly that word from xAPIC and checks three things: `wr_err` pulses, `swen_clr` stays low, and the mode and base are unchanged. A second case sends a plain disable and checks the opposite outcome, so the refusal check is shown to take priority over the disable handling.

// File: rtl/apic_mode_ctl.sv
module apic_mode_ctl #(
  parameter int               BASE_W   = 20,
  parameter int               ID_W     = 32,
  parameter logic [BASE_W-1:0] BASE_RST = 20'hFEE00,
  parameter int               EN_BIT   = 11,
  parameter int               EXT_BIT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bsp_in,
  input  logic              x2_capable,
  input  logic [ID_W-1:0]   init_id,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [1:0]        mode,
  output logic [BASE_W-1:0] base_addr,
  output logic              bsp,
  output logic [31:0]       log_id,
  output logic              wr_err,
  output logic              swen_clr
);
  localparam int BASE_LSB = 32 - BASE_W;

  logic en_q, ext_q;
  logic req_en, req_ext, bad;
  logic [31:0] new_log;

  assign req_en  = wr_data[EN_BIT];
  assign req_ext = wr_data[EXT_BIT];
  assign mode    = {ext_q, en_q};

  assign bad = (req_ext && !x2_capable)
             || (req_ext && !req_en)
             || (!en_q && !ext_q && req_en && req_ext)
             || (en_q && ext_q && req_en && !req_ext);

  assign new_log = {init_id[19:4], 16'b0} | (32'd1 << init_id[3:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b1;
      ext_q     <= 1'b0;
      bsp       <= bsp_in;
      base_addr <= BASE_RST;
      log_id    <= '0;
      wr_err    <= 1'b0;
      swen_clr  <= 1'b0;
    end else begin
      wr_err   <= 1'b0;
      swen_clr <= 1'b0;
      if (wr_en) begin
        if (bad) begin
          wr_err <= 1'b1;
        end else begin
          base_addr <= wr_data[31:BASE_LSB];
          if (!req_en) begin
            en_q     <= 1'b0;
            ext_q    <= 1'b0;
            swen_clr <= 1'b1;
          end else begin
            en_q <= 1'b1;
            if (req_ext && !ext_q) begin
              ext_q  <= 1'b1;
              log_id <= new_log;
            end
          end
        end
      end
    end
  end

  AST_ERR_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> ($stable(mode) && $stable(base_addr) && $stable(log_id))); // R6
  AST_ERR_NOT_WITH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_err && swen_clr)); // R6
  AST_CLR_MEANS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    swen_clr |-> (mode == 2'b00)); // R8
  AST_X2_FROM_XAPIC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && $past(mode) != 2'b11) |-> ($past(mode) == 2'b01)); // R4
  AST_X2_NO_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b11) |-> (mode != 2'b01)); // R5
  AST_X2_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && $past(mode) != 2'b11) |-> $past(x2_capable)); // R2
  AST_BSP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(bsp)); // R7
endmodule

// File: tb/sim_apic_mode_ctl.sv
module sim_apic_mode_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bsp_in = 1'b1;
  logic x2_capable = 1'b1;
  logic [31:0] init_id = '0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0] mode;
  logic [19:0] base_addr;
  logic bsp, wr_err, swen_clr;
  logic [31:0] log_id;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  apic_mode_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bsp_in(bsp_in), .x2_capable(x2_capable),
    .init_id(init_id), .wr_en(wr_en), .wr_data(wr_data), .mode(mode),
    .base_addr(base_addr), .bsp(bsp), .log_id(log_id), .wr_err(wr_err),
    .swen_clr(swen_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [19:0] b, input logic en, input logic ext);
    return {b, en, ext, 10'b0};
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 mode", 32'(mode), 32'h1);
    chk("R1 bsp", 32'(bsp), 32'h1);
    chk("R1 base", 32'(base_addr), 32'hFEE00);
    chk("R1 log_id", log_id, 32'h0);
    chk("R1 err", 32'({wr_err, swen_clr}), 32'h0);
  endtask

  task automatic t_base;
    wr(word(20'h12345, 1'b1, 1'b0));
    chk("R7 base", 32'(base_addr), 32'h12345);
    chk("R7 bsp", 32'(bsp), 32'h1);
    chk("R7 mode", 32'(mode), 32'h1);
    chk("R7 err", 32'(wr_err), 32'h0);
  endtask

  task automatic t_no_cap;
    x2_capable = 1'b0;
    wr(word(20'hABCDE, 1'b1, 1'b1));
    chk("R2 err", 32'(wr_err), 32'h1);
    chk("R2 mode", 32'(mode), 32'h1);
    chk("R6 base", 32'(base_addr), 32'h12345);
    @(negedge clk);
    chk("R6 err one cycle", 32'(wr_err), 32'h0);
    x2_capable = 1'b1;
  endtask

  task automatic t_ext_noen;
    wr(word(20'hAAAAA, 1'b0, 1'b1));
    chk("R3 err", 32'(wr_err), 32'h1);
    chk("R3 no clr", 32'(swen_clr), 32'h0);
    chk("R3 mode", 32'(mode), 32'h1);
    chk("R6 base", 32'(base_addr), 32'h12345);
  endtask

  task automatic t_to_x2;
    init_id = 32'h0005A3C7;
    wr(word(20'h22222, 1'b1, 1'b1));
    chk("R10 mode", 32'(mode), 32'h3);
    chk("R10 log_id", log_id, 32'h5A3C0080);
    chk("R10 base", 32'(base_addr), 32'h22222);
  endtask

  task automatic t_x2_keep;
    init_id = 32'h00012345;
    wr(word(20'h33333, 1'b1, 1'b1));
    chk("R11 mode", 32'(mode), 32'h3);
    chk("R11 log_id", log_id, 32'h5A3C0080);
    chk("R11 err", 32'(wr_err), 32'h0);
  endtask

  task automatic t_x2_back;
    wr(word(20'h77777, 1'b1, 1'b0));
    chk("R5 err", 32'(wr_err), 32'h1);
    chk("R5 mode", 32'(mode), 32'h3);
    chk("R6 base", 32'(base_addr), 32'h33333);
  endtask

  task automatic t_disable;
    wr(word(20'h44444, 1'b0, 1'b0));
    chk("R8 mode", 32'(mode), 32'h0);
    chk("R8 clr", 32'(swen_clr), 32'h1);
    chk("R8 err", 32'(wr_err), 32'h0);
    chk("R7 base", 32'(base_addr), 32'h44444);
    @(negedge clk);
    chk("R8 clr one cycle", 32'(swen_clr), 32'h0);
  endtask

  task automatic t_dis_to_x2;
    wr(word(20'h66666, 1'b1, 1'b1));
    chk("R4 err", 32'(wr_err), 32'h1);
    chk("R4 mode", 32'(mode), 32'h0);
  endtask

  task automatic t_reenable;
    wr(word(20'h55555, 1'b1, 1'b0) | 32'h100);
    chk("R9 mode", 32'(mode), 32'h1);
    chk("R9 clr", 32'(swen_clr), 32'h0);
    chk("R7 bsp kept", 32'(bsp), 32'h1);
  endtask

  initial begin
    #4000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base();
    t_no_cap();
    t_ext_noen();
    t_to_x2();
    t_x2_keep();
    t_x2_back();
    t_disable();
    t_dis_to_x2();
    t_reenable();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule